// File: doc/BRIEF.md
# Direct-Mapped Data Translation Buffer

This block caches virtual-to-physical page translations for a 32-bit data memory path. It holds 64 entries in a single way, with 8 KB pages. On a lookup the caller presents a virtual address with an enable. Address bits 18..13 pick one entry. The stored 13-bit tag is compared against address bits 31..19. One clock later the block returns a hit flag, the 19-bit physical page number, four access permissions (supervisor write/read, user write/read) and a cache-inhibit flag.

Software fills and inspects the entries through a register port. Each entry appears as two 32-bit words. The tag word holds the page tag and the valid flag. The frame word holds the physical page, the permissions and the cache-inhibit flag. The two kinds of word sit in two separate 64-word address windows and are packed into 38 bits of state per entry. Raising and checking faults from these outputs, walking page tables and driving the cache are left to the surrounding logic.

Top module: `dtlb_top`

## Requirements
- R1: While rst_n is low and after its release, every entry is invalid, so every lookup misses until software writes a tag word with the valid bit set. reg_rdata is zero after reset.
- R2: A lookup with lk_en high at a clock edge indexes entry lk_vaddr[18:13]. From the next cycle lk_hit is 1 exactly when that entry is valid and its tag equals lk_vaddr[31:19].
- R3: With the same one-cycle latency, lk_ppn carries the entry's physical page. lk_swe, lk_sre, lk_uwe, lk_ure and lk_ci carry its permission and cache-inhibit flags.
- R4: Tag word layout: bits 31..19 are the tag and bit 0 is the valid flag. Bits 18..10 are accepted on write but discarded. Reading back returns the tag and the valid flag, with every other bit zero.
- R5: Frame word layout: bits 31..13 are the physical page, bit 9 supervisor write, bit 8 supervisor read, bit 7 user write, bit 6 user read and bit 1 cache inhibit. Every other bit reads back as zero.
- R6: Tag words live at register addresses 0x0A00+n and frame words at 0x0B00+n, for entry n in 0..63. A write outside both windows changes no entry, and a read outside both windows returns zero.
- R7: A read (reg_cs high, reg_we low) returns its word on reg_rdata in the cycle after the request. reg_rdata is zero in any cycle that follows a cycle with reg_cs low or with a write.
- R8: When a register write and a lookup of the same entry share a clock edge, that lookup sees the entry's old contents. A lookup issued on the following cycle sees the new contents.
- R9: After a cycle with lk_en low, lk_hit is 0. lk_ppn and the permission and cache-inhibit outputs keep the values of the last lookup.
- R10: Entries are independent. Writing one entry does not change a lookup or a read of any other entry, and two addresses with the same index but different tags cannot both hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_en | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found (registered) |
| lk_ppn | output | 19 | Physical page number |
| lk_swe | output | 1 | Supervisor write permitted |
| lk_sre | output | 1 | Supervisor read permitted |
| lk_uwe | output | 1 | User write permitted |
| lk_ure | output | 1 | User read permitted |
| lk_ci | output | 1 | Cache inhibit for the page |
| reg_cs | input | 1 | Register port select |
| reg_we | input | 1 | Register write (1) or read (0) |
| reg_addr | input | 16 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, zero when idle |

## Verification
The bench writes all-ones words to check that the discarded and unimplemented bits read back as zero. A design that stored the full 22-bit page field or left those bits floating fails here. It then aims at aliasing: an address with the right index but the wrong tag must miss, which catches a comparator that checks too few bits or ignores the valid flag. A lookup and a write to the same entry on one edge must return the old translation, so a design that forwards the write data is caught. Addresses just past each 64-word window must be ignored, which catches a decoder that wraps the index, and hit must drop on an idle cycle while the page number holds.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
    localparam int ADDR_W    = 32;
    localparam int PAGE_BITS = 13;
    localparam int ENTRIES   = 64;
    localparam int IDX_W     = $clog2(ENTRIES);
    localparam int TAG_W     = ADDR_W - PAGE_BITS - IDX_W;
    localparam int PPN_W     = ADDR_W - PAGE_BITS;
    localparam int WORD_W    = 32;
    localparam int RADDR_W   = 16;

    localparam int VALID_BIT = 0;
    localparam int CI_BIT    = 1;
    localparam int URE_BIT   = 6;
    localparam int UWE_BIT   = 7;
    localparam int SRE_BIT   = 8;
    localparam int SWE_BIT   = 9;

    typedef struct packed {
        logic swe;
        logic sre;
        logic uwe;
        logic ure;
    } perm_t;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
        perm_t            perm;
        logic             ci;
    } entry_t;

    typedef enum logic [1:0] {
        WIN_NONE  = 2'd0,
        WIN_MATCH = 2'd1,
        WIN_XLAT  = 2'd2
    } win_e;

    function automatic logic [WORD_W-1:0] pack_match(entry_t e);
        logic [WORD_W-1:0] w;
        w = '0;
        w[WORD_W-1 -: TAG_W] = e.tag;
        w[VALID_BIT]         = e.valid;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_xlat(entry_t e);
        logic [WORD_W-1:0] w;
        w = '0;
        w[WORD_W-1 -: PPN_W] = e.ppn;
        w[SWE_BIT]           = e.perm.swe;
        w[SRE_BIT]           = e.perm.sre;
        w[UWE_BIT]           = e.perm.uwe;
        w[URE_BIT]           = e.perm.ure;
        w[CI_BIT]            = e.ci;
        return w;
    endfunction
endpackage

// File: rtl/dtlb_reg_decode.sv
module dtlb_reg_decode
    import dtlb_pkg::*;
#(
    parameter logic [RADDR_W-1:0] MATCH_BASE = 16'h0A00,
    parameter logic [RADDR_W-1:0] XLAT_BASE  = 16'h0B00
) (
    input  logic [RADDR_W-1:0] addr,
    output win_e               win,
    output logic [IDX_W-1:0]   idx
);
    localparam int HI_W = RADDR_W - IDX_W;

    logic [HI_W-1:0] hi;

    always_comb begin
        hi  = addr[RADDR_W-1:IDX_W];
        idx = addr[IDX_W-1:0];
        if (hi == MATCH_BASE[RADDR_W-1:IDX_W])
            win = WIN_MATCH;
        else if (hi == XLAT_BASE[RADDR_W-1:IDX_W])
            win = WIN_XLAT;
        else
            win = WIN_NONE;
    end
endmodule

// File: rtl/dtlb_store.sv
module dtlb_store
    import dtlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  win_e              wr_win,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output entry_t            lk_entry,
    output entry_t            rd_entry
);
    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
    } store_t;

    store_t st_d, st_q;
    logic   unused_wdata_bits;

    assign unused_wdata_bits = ^wr_data;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_win)
                WIN_MATCH: begin
                    st_d.ent[wr_idx].valid = wr_data[VALID_BIT];
                    st_d.ent[wr_idx].tag   = wr_data[WORD_W-1 -: TAG_W];
                end
                WIN_XLAT: begin
                    st_d.ent[wr_idx].ppn      = wr_data[WORD_W-1 -: PPN_W];
                    st_d.ent[wr_idx].perm.swe = wr_data[SWE_BIT];
                    st_d.ent[wr_idx].perm.sre = wr_data[SRE_BIT];
                    st_d.ent[wr_idx].perm.uwe = wr_data[UWE_BIT];
                    st_d.ent[wr_idx].perm.ure = wr_data[URE_BIT];
                    st_d.ent[wr_idx].ci       = wr_data[CI_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lk_entry = st_q.ent[lk_idx];
    assign rd_entry = st_q.ent[rd_idx];
endmodule

// File: rtl/dtlb_lookup.sv
module dtlb_lookup
    import dtlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [TAG_W-1:0] tag_in,
    input  entry_t           entry,
    output logic             hit,
    output logic [PPN_W-1:0] ppn,
    output perm_t            perm,
    output logic             ci
);
    typedef struct packed {
        logic             hit;
        logic [PPN_W-1:0] ppn;
        perm_t            perm;
        logic             ci;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d     = res_q;
        res_d.hit = 1'b0;
        if (en) begin
            res_d.hit  = entry.valid && (entry.tag == tag_in);
            res_d.ppn  = entry.ppn;
            res_d.perm = entry.perm;
            res_d.ci   = entry.ci;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign hit  = res_q.hit;
    assign ppn  = res_q.ppn;
    assign perm = res_q.perm;
    assign ci   = res_q.ci;
endmodule

// File: rtl/dtlb_top.sv
module dtlb_top
    import dtlb_pkg::*;
#(
    parameter logic [RADDR_W-1:0] MATCH_BASE = 16'h0A00,
    parameter logic [RADDR_W-1:0] XLAT_BASE  = 16'h0B00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_en,
    input  logic [ADDR_W-1:0] lk_vaddr,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic              lk_swe,
    output logic              lk_sre,
    output logic              lk_uwe,
    output logic              lk_ure,
    output logic              lk_ci,
    input  logic              reg_cs,
    input  logic              reg_we,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata
);
    win_e             win;
    logic [IDX_W-1:0] reg_idx;
    logic             wr_en;
    entry_t           lk_entry, rd_entry;
    perm_t            perm;
    logic             unused_offset_bits;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    assign unused_offset_bits = ^lk_vaddr[PAGE_BITS-1:0];
    assign wr_en = reg_cs && reg_we && (win != WIN_NONE);

    dtlb_reg_decode #(
        .MATCH_BASE(MATCH_BASE),
        .XLAT_BASE (XLAT_BASE)
    ) dec_i (
        .addr(reg_addr),
        .win (win),
        .idx (reg_idx)
    );

    dtlb_store store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_win  (win),
        .wr_idx  (reg_idx),
        .wr_data (reg_wdata),
        .lk_idx  (lk_vaddr[PAGE_BITS +: IDX_W]),
        .rd_idx  (reg_idx),
        .lk_entry(lk_entry),
        .rd_entry(rd_entry)
    );

    dtlb_lookup lookup_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (lk_en),
        .tag_in(lk_vaddr[ADDR_W-1 -: TAG_W]),
        .entry (lk_entry),
        .hit   (lk_hit),
        .ppn   (lk_ppn),
        .perm  (perm),
        .ci    (lk_ci)
    );

    assign lk_swe = perm.swe;
    assign lk_sre = perm.sre;
    assign lk_uwe = perm.uwe;
    assign lk_ure = perm.ure;

    always_comb begin
        rd_d = '0;
        if (reg_cs && !reg_we) begin
            case (win)
                WIN_MATCH: rd_d.rdata = pack_match(rd_entry);
                WIN_XLAT:  rd_d.rdata = pack_xlat(rd_entry);
                default:   rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign reg_rdata = rd_q.rdata;
endmodule

// File: rtl/dtlb_checker.sv
module dtlb_checker
    import dtlb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              lk_en,
    input logic              lk_hit,
    input logic [PPN_W-1:0]  lk_ppn,
    input logic              lk_ci,
    input logic              reg_cs,
    input logic              reg_we,
    input logic [WORD_W-1:0] reg_rdata
);
    // R7: no request in the previous cycle gives zero read data
    a_r7_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_cs |=> (reg_rdata == '0));

    // R7: a write never returns data
    a_r7_write_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_cs && reg_we) |=> (reg_rdata == '0));

    // R9: an idle lookup cycle drops hit
    a_r9_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_en |=> !lk_hit);

    // R9: an idle lookup cycle keeps the page number
    a_r9_idle_ppn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_en |=> $stable(lk_ppn));

    // R9: an idle lookup cycle keeps the cache-inhibit flag
    a_r9_idle_ci_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_en |=> $stable(lk_ci));
endmodule

bind dtlb_top dtlb_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_en    (lk_en),
    .lk_hit   (lk_hit),
    .lk_ppn   (lk_ppn),
    .lk_ci    (lk_ci),
    .reg_cs   (reg_cs),
    .reg_we   (reg_we),
    .reg_rdata(reg_rdata)
);

// File: tb/dtlb_top_tb_top.sv
`timescale 1ns/1ps
module dtlb_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_en = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit;
    logic [18:0] lk_ppn;
    logic        lk_swe, lk_sre, lk_uwe, lk_ure, lk_ci;
    logic        reg_cs = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dtlb_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_en(lk_en), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn),
        .lk_swe(lk_swe), .lk_sre(lk_sre), .lk_uwe(lk_uwe), .lk_ure(lk_ure),
        .lk_ci(lk_ci),
        .reg_cs(reg_cs), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] va(input logic [12:0] tag, input logic [5:0] idx);
        return {tag, idx, 13'h0};
    endfunction

    function automatic logic [31:0] mword(input logic [12:0] tag, input logic v);
        return {tag, 18'h0, v};
    endfunction

    function automatic logic [31:0] xword(input logic [18:0] ppn, input logic [3:0] p, input logic ci);
        return {ppn, 3'b0, p, 4'b0, ci, 1'b0};
    endfunction

    task automatic reg_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_cs = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_cs = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_cs = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_cs = 1'b0;
        d = reg_rdata;
    endtask

    task automatic lookup(input logic [31:0] a);
        @(negedge clk);
        lk_en = 1'b1; lk_vaddr = a;
        @(negedge clk);
        lk_en = 1'b0;
    endtask

    function automatic logic [31:0] lk_pack();
        return {lk_ppn, 6'b0, lk_swe, lk_sre, lk_uwe, lk_ure, lk_ci, lk_hit};
    endfunction

    task automatic t_reset();
        logic [31:0] r;
        check("R1 rdata after reset", reg_rdata, 32'h0);
        lookup(va(13'h0, 6'd5));
        check("R1 miss after reset", {31'b0, lk_hit}, 32'h0);
        reg_read(16'h0A05, r);
        check("R1 tag word clear", r, 32'h0);
    endtask

    task automatic t_readback();
        logic [31:0] r;
        reg_write(16'h0A3F, 32'hFFFF_FFFF);
        reg_read(16'h0A3F, r);
        check("R4 tag word readback", r, 32'hFFF8_0001);
        reg_write(16'h0B3F, 32'hFFFF_FFFF);
        reg_read(16'h0B3F, r);
        check("R5 frame word readback", r, 32'hFFFF_E3C2);
        @(negedge clk);
        check("R7 rdata zero when idle", reg_rdata, 32'h0);
    endtask

    task automatic t_hit_miss();
        reg_write(16'h0A07, mword(13'h1ABC, 1'b1));
        reg_write(16'h0B07, xword(19'h5_4321, 4'b1010, 1'b1));
        lookup(va(13'h1ABC, 6'd7) | 32'h0000_1234);
        check("R2 hit on matching tag", {31'b0, lk_hit}, 32'h1);
        check("R3 ppn/perm/ci", lk_pack(), {19'h5_4321, 6'b0, 4'b1010, 1'b1, 1'b1});
        lookup(va(13'h1ABD, 6'd7));
        check("R10 same index other tag misses", {31'b0, lk_hit}, 32'h0);
        lookup(va(13'h1ABC, 6'd8));
        check("R10 other index misses", {31'b0, lk_hit}, 32'h0);
        reg_write(16'h0A07, mword(13'h1ABC, 1'b0));
        lookup(va(13'h1ABC, 6'd7));
        check("R2 invalid entry misses", {31'b0, lk_hit}, 32'h0);
    endtask

    task automatic t_perms();
        for (int i = 0; i < 4; i++) begin
            logic [3:0] p;
            p = 4'b0001 << i;
            reg_write(16'h0A10 + 16'(i), mword(13'h0100 + 13'(i), 1'b1));
            reg_write(16'h0B10 + 16'(i), xword(19'h0_0100 + 19'(i), p, i[0]));
            lookup(va(13'h0100 + 13'(i), 6'(16 + i)));
            check("R3 permission bit position", lk_pack(),
                  {19'h0_0100 + 19'(i), 6'b0, p, i[0], 1'b1});
        end
    endtask

    task automatic t_window();
        logic [31:0] r;
        reg_write(16'h0A20, mword(13'h0777, 1'b1));
        reg_write(16'h0A40, mword(13'h0FFF, 1'b1));
        reg_write(16'h0B40, 32'hFFFF_FFFF);
        reg_write(16'h0C20, 32'hFFFF_FFFF);
        reg_read(16'h0A20, r);
        check("R6 out-of-window write ignored", r, mword(13'h0777, 1'b1));
        reg_read(16'h0B00, r);
        check("R6 frame entry 0 untouched", r, 32'h0);
        reg_read(16'h0A40, r);
        check("R6 out-of-window read zero", r, 32'h0);
        lookup(va(13'h0777, 6'd32));
        check("R10 entry 32 still hits", {31'b0, lk_hit}, 32'h1);
    endtask

    task automatic t_concurrent();
        reg_write(16'h0A2A, mword(13'h0AAA, 1'b1));
        reg_write(16'h0B2A, xword(19'h1_1111, 4'b0000, 1'b0));
        @(negedge clk);
        lk_en = 1'b1; lk_vaddr = va(13'h0AAA, 6'd42);
        reg_cs = 1'b1; reg_we = 1'b1; reg_addr = 16'h0B2A;
        reg_wdata = xword(19'h2_2222, 4'b1111, 1'b1);
        @(negedge clk);
        lk_en = 1'b0; reg_cs = 1'b0; reg_we = 1'b0;
        check("R8 same-edge lookup sees old", lk_pack(), {19'h1_1111, 6'b0, 4'b0000, 1'b0, 1'b1});
        lookup(va(13'h0AAA, 6'd42));
        check("R8 next lookup sees new", lk_pack(), {19'h2_2222, 6'b0, 4'b1111, 1'b1, 1'b1});
    endtask

    task automatic t_idle_hold();
        logic [31:0] r;
        lookup(va(13'h0AAA, 6'd42));
        @(negedge clk);
        check("R9 idle drops hit, holds rest", lk_pack(), {19'h2_2222, 6'b0, 4'b1111, 1'b1, 1'b0});
        @(negedge clk);
        reg_cs = 1'b1; reg_we = 1'b1; reg_addr = 16'h0A2A; reg_wdata = mword(13'h0AAA, 1'b1);
        @(negedge clk);
        reg_cs = 1'b0; reg_we = 1'b0;
        check("R7 rdata zero after write", reg_rdata, 32'h0);
        reg_read(16'h0B2A, r);
        check("R7 read returns word", r, xword(19'h2_2222, 4'b1111, 1'b1));
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_hit_miss();
        t_perms();
        t_window();
        t_concurrent();
        t_idle_hold();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule